// File: doc/BRIEF.md
# Epoch-Tagged Misprediction Redirect Controller

This block couples the fetch half and the execute half of a two-stage processor pipeline and makes sure that instructions fetched down a wrong path never take effect. Fetch keeps a program counter and a one-bit epoch. Each instruction it issues carries its own address, the next address the external predictor proposed, and the fetch epoch at that moment. These travel through a one-entry hand-off register to execute. Execute keeps its own epoch bit and acts only on instructions whose tag matches it. Any other instruction is discarded without side effects.

When execute finds that an instruction's real successor differs from the predicted one, it toggles its epoch. It also pushes a resolution record onto a small queue back to fetch. Control-transfer instructions push a record even when the prediction was right, so that the predictor can learn from it. Fetch drains one record per cycle and presents it on the predictor-update port. Only a record flagged as a mispredict reloads the program counter and toggles the fetch epoch. The register file, the scoreboard and data memory are outside the block. They appear only as an issue enable, an execute-ready input and a release pulse.

Top module: `epoch_redirect_ctl`

## Requirements
- R1: While reset is asserted, the fetch address is RESET_PC, no instruction is visible to execute, no record is offered to the predictor, and no retire or drop pulse occurs. Both epochs start at 0, so the first instruction issued after reset is executed, not dropped.
- R2: An issued instruction appears at the execute outputs in the next cycle. It carries the fetch address it was issued from and the predictor's proposal for that address.
- R3: With no mispredict record pending, each issue moves the fetch address to the predictor output. With the issue enable low, the address holds.
- R4: An instruction whose epoch tag differs from the execute epoch is dropped in the cycle it reaches execute. It is neither retired nor recorded, even if it is a control transfer.
- R5: A retired instruction whose actual next address differs from its predicted next address pushes a record with the mispredict flag set and toggles the execute epoch. This also holds for a non-control instruction (kind 0). The instructions already fetched behind it are dropped.
- R6: A retired instruction of kind jump (1), register jump (2) or branch (3) pushes a record {address, actual next address, taken, mispredict} even when correctly predicted. A correctly predicted kind 0 instruction pushes none.
- R7: Fetch consumes a mispredict record in the cycle after it was pushed. That cycle it presents the record on the update port, issues nothing, and then fetches from the record's next address under the toggled epoch.
- R8: A record without the mispredict flag only updates the predictor. Fetch issues in that cycle as usual and its address is not overridden.
- R9: Execute does not retire an instruction that must push a record while the redirect queue is full. It retires that instruction once space is available.
- R10: Every instruction leaving the hand-off register, whether retired or dropped, produces exactly one release pulse.
- R11: While the execute-ready input is low, a matching instruction stays in the hand-off register and fetch stops issuing once that register is occupied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| f_pc | output | ADDR_W | Current fetch address, also the predictor lookup key |
| f_pred_npc | input | ADDR_W | Predictor's proposed next address for f_pc |
| f_go | input | 1 | Fetch may issue this cycle (decode not stalled) |
| x_valid | output | 1 | A matching-epoch instruction is waiting in execute |
| x_pc | output | ADDR_W | Address of the instruction in execute |
| x_ppc | output | ADDR_W | Predicted next address of the instruction in execute |
| x_ok | input | 1 | Execute resources ready |
| x_kind | input | 2 | Resolved kind: 0 other, 1 jump, 2 register jump, 3 branch |
| x_npc | input | ADDR_W | Resolved actual next address |
| x_taken | input | 1 | Resolved taken flag |
| x_retire | output | 1 | Instruction executed this cycle |
| x_drop | output | 1 | Wrong-epoch instruction discarded this cycle |
| x_release | output | 1 | Reservation release pulse for any dequeued instruction |
| u_valid | output | 1 | Resolution record offered to the predictor |
| u_pc | output | ADDR_W | Record: instruction address |
| u_npc | output | ADDR_W | Record: actual next address |
| u_taken | output | 1 | Record: taken flag |
| u_mispred | output | 1 | Record: mispredict flag |

## Verification
The hardest state to reach is a full redirect queue. Fetch drains one record every cycle, so with a deep queue execute can never fill it. The bench therefore builds the block with a one-entry queue and places two correctly predicted branches back to back. The second branch must then wait one cycle, which the bench sees as a wider gap between the two retire pulses. The wrong-path window is reached in a similar way: a mispredicted branch is followed at once by a jump that is fetched on the old epoch, and that jump must vanish without leaving a record.

// File: rtl/erc_pkg.sv
package erc_pkg;
   typedef enum logic [1:0] {
      K_OTHER  = 2'd0,
      K_JUMP   = 2'd1,
      K_JREG   = 2'd2,
      K_BRANCH = 2'd3
   } kind_e;

   function automatic logic is_ctrl(input kind_e k);
      return k != K_OTHER;
   endfunction
endpackage

// File: rtl/erc_redirect_fifo.sv
module erc_redirect_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic         full,
   output logic         nonempty,
   output logic [W-1:0] dout
);
   localparam int CW = $clog2(DEPTH + 1);

   logic [CW-1:0] cnt;
   logic          pop_eff;

   assign pop_eff  = pop && nonempty;
   assign full     = (cnt == CW'(DEPTH));
   assign nonempty = (cnt != '0);

   always_ff @(posedge clk) begin
      if (!rst_n) cnt <= '0;
      else        cnt <= cnt + CW'(push) - CW'(pop_eff);
   end

   generate
      if (DEPTH < 1) begin : g_bad_depth
         $error("redirect queue depth must be at least 1");
      end
      if (DEPTH == 1) begin : g_single
         logic [W-1:0] slot;
         always_ff @(posedge clk) begin
            if (push) slot <= din;
         end
         assign dout = slot;
      end else begin : g_ring
         localparam int PW = $clog2(DEPTH);
         logic [W-1:0]  mem [DEPTH];
         logic [PW-1:0] rd_p, wr_p;
         always_ff @(posedge clk) begin
            if (push) mem[wr_p] <= din;
         end
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               rd_p <= '0;
               wr_p <= '0;
            end else begin
               if (push)    wr_p <= (wr_p == PW'(DEPTH - 1)) ? '0 : wr_p + 1'b1;
               if (pop_eff) rd_p <= (rd_p == PW'(DEPTH - 1)) ? '0 : rd_p + 1'b1;
            end
         end
         assign dout = mem[rd_p];
      end
   endgenerate

   // R9: execute must never push into a full queue
   a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full);
   a_r9_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(DEPTH));
endmodule

// File: rtl/erc_fetch.sv
module erc_fetch #(
   parameter int              ADDR_W   = 32,
   parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go,
   input  logic [ADDR_W-1:0] pred_npc,
   input  logic              slot_free,
   input  logic              rq_valid,
   input  logic              rq_mis,
   input  logic [ADDR_W-1:0] rq_npc,
   output logic [ADDR_W-1:0] pc,
   output logic              epoch,
   output logic              issue,
   output logic              rq_pop
);
   logic take_mis;

   assign take_mis = rq_valid && rq_mis;
   assign rq_pop   = rq_valid;
   assign issue    = go && slot_free && !take_mis;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc    <= RESET_PC;
         epoch <= 1'b0;
      end else if (take_mis) begin
         pc    <= rq_npc;
         epoch <= ~epoch;
      end else if (issue) begin
         pc    <= pred_npc;
      end
   end

   a_r7_no_issue_on_redirect: assert property (@(posedge clk) disable iff (!rst_n)
      take_mis |-> !issue);
   a_r7_pc_reload: assert property (@(posedge clk) disable iff (!rst_n)
      take_mis |=> pc == $past(rq_npc));
   a_r8_epoch_steady: assert property (@(posedge clk) disable iff (!rst_n)
      !take_mis |=> $stable(epoch));
   a_r3_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!take_mis && !issue) |=> $stable(pc));
endmodule

// File: rtl/erc_execute.sv
module erc_execute
   import erc_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_issue,
   input  logic [ADDR_W-1:0] in_pc,
   input  logic [ADDR_W-1:0] in_ppc,
   input  logic              in_epoch,
   output logic              slot_free,
   input  logic              ok,
   input  logic [1:0]        kind,
   input  logic [ADDR_W-1:0] npc,
   input  logic              taken,
   input  logic              q_full,
   output logic              q_push,
   output logic [ADDR_W-1:0] hd_pc,
   output logic [ADDR_W-1:0] hd_ppc,
   output logic              hd_match,
   output logic              mis,
   output logic              retire,
   output logic              drop
);
   logic v, tag, ex_epoch, need_rec, deq;

   assign hd_match  = v && (tag == ex_epoch);
   assign mis       = (npc != hd_ppc);
   assign need_rec  = is_ctrl(kind_e'(kind)) || mis;
   assign retire    = hd_match && ok && !(need_rec && q_full);
   assign drop      = v && (tag != ex_epoch);
   assign deq       = retire || drop;
   assign slot_free = !v || deq;
   assign q_push    = retire && need_rec;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         v        <= 1'b0;
         ex_epoch <= 1'b0;
      end else begin
         if (in_issue)   v <= 1'b1;
         else if (deq)   v <= 1'b0;
         if (retire && mis) ex_epoch <= ~ex_epoch;
      end
   end

   always_ff @(posedge clk) begin
      if (in_issue) begin
         hd_pc  <= in_pc;
         hd_ppc <= in_ppc;
         tag    <= in_epoch;
      end
   end

   a_r4_drop_silent: assert property (@(posedge clk) disable iff (!rst_n)
      drop |-> (!q_push && !retire));
   a_r5_epoch_flip: assert property (@(posedge clk) disable iff (!rst_n)
      (retire && mis) |=> ex_epoch != $past(ex_epoch));
   a_r5_epoch_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(retire && mis) |=> $stable(ex_epoch));
   a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
      in_issue |=> (v && hd_pc == $past(in_pc) && hd_ppc == $past(in_ppc)));
   a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (v && !deq) |=> (v && $stable(hd_pc)));
   a_r10_one_exit: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({retire, drop}));
endmodule

// File: rtl/epoch_redirect_ctl.sv
module epoch_redirect_ctl #(
   parameter int              ADDR_W   = 32,
   parameter logic [ADDR_W-1:0] RESET_PC = ADDR_W'(32'h100),
   parameter int              QDEPTH   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic [ADDR_W-1:0] f_pc,
   input  logic [ADDR_W-1:0] f_pred_npc,
   input  logic              f_go,
   output logic              x_valid,
   output logic [ADDR_W-1:0] x_pc,
   output logic [ADDR_W-1:0] x_ppc,
   input  logic              x_ok,
   input  logic [1:0]        x_kind,
   input  logic [ADDR_W-1:0] x_npc,
   input  logic              x_taken,
   output logic              x_retire,
   output logic              x_drop,
   output logic              x_release,
   output logic              u_valid,
   output logic [ADDR_W-1:0] u_pc,
   output logic [ADDR_W-1:0] u_npc,
   output logic              u_taken,
   output logic              u_mispred
);
   localparam int REC_W = 2 * ADDR_W + 2;

   generate
      if (ADDR_W < 3) begin : g_bad_width
         $error("address width must be at least 3");
      end
   endgenerate

   logic              f_epoch, issue, rq_pop, slot_free;
   logic              q_full, q_push, q_nonempty, mis;
   logic [REC_W-1:0]  q_din, q_dout;

   erc_fetch #(.ADDR_W(ADDR_W), .RESET_PC(RESET_PC)) u_fetch (
      .clk(clk), .rst_n(rst_n), .go(f_go), .pred_npc(f_pred_npc),
      .slot_free(slot_free), .rq_valid(q_nonempty), .rq_mis(u_mispred),
      .rq_npc(u_npc), .pc(f_pc), .epoch(f_epoch), .issue(issue),
      .rq_pop(rq_pop)
   );

   erc_execute #(.ADDR_W(ADDR_W)) u_exec (
      .clk(clk), .rst_n(rst_n), .in_issue(issue), .in_pc(f_pc),
      .in_ppc(f_pred_npc), .in_epoch(f_epoch), .slot_free(slot_free),
      .ok(x_ok), .kind(x_kind), .npc(x_npc), .taken(x_taken),
      .q_full(q_full), .q_push(q_push), .hd_pc(x_pc), .hd_ppc(x_ppc),
      .hd_match(x_valid), .mis(mis), .retire(x_retire), .drop(x_drop)
   );

   assign q_din = {x_pc, x_npc, x_taken, mis};

   erc_redirect_fifo #(.W(REC_W), .DEPTH(QDEPTH)) u_rq (
      .clk(clk), .rst_n(rst_n), .push(q_push), .din(q_din), .pop(rq_pop),
      .full(q_full), .nonempty(q_nonempty), .dout(q_dout)
   );

   assign u_valid   = q_nonempty;
   assign u_pc      = q_dout[REC_W-1 -: ADDR_W];
   assign u_npc     = q_dout[ADDR_W+1 -: ADDR_W];
   assign u_taken   = q_dout[1];
   assign u_mispred = q_dout[0];
   assign x_release = x_retire || x_drop;

   // R7: a mispredict record is taken up in the cycle after its push
   a_r7_prompt_consume: assert property (@(posedge clk) disable iff (!rst_n)
      (q_push && !q_nonempty) |=> u_valid);
   a_r1_quiet_after_reset: assert property (@(posedge clk)
      !rst_n |=> (!x_valid && !u_valid));
endmodule

// File: tb/sim_epoch_redirect_ctl.sv
`timescale 1ns/1ps
module sim_epoch_redirect_ctl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] f_pc, pred, x_pc, x_ppc, x_npc, u_pc, u_npc;
   logic        f_go = 1'b0, x_ok = 1'b1, x_taken;
   logic [1:0]  x_kind;
   logic        x_valid, x_retire, x_drop, x_release, u_valid, u_taken, u_mispred;

   // bench-side program and predictor model
   logic        pg_en [4];
   logic [31:0] pg_pc [4], pg_tgt [4];
   logic [1:0]  pg_kind [4];
   logic        pp_en [2];
   logic [31:0] pp_from [2], pp_to [2];

   int checks = 0, errors = 0, cyc = 0;
   int n_ret, n_drop, n_rec, n_rel, ppc_bad;
   logic [31:0] ret_pc [64];
   int          ret_cyc [64];
   logic [31:0] drop_pc [64];
   logic [31:0] rec_pc [64], rec_npc [64];
   logic        rec_tk [64], rec_mis [64];

   always #4 clk = ~clk;

   epoch_redirect_ctl #(.ADDR_W(32), .RESET_PC(32'h100), .QDEPTH(1)) u0 (
      .clk(clk), .rst_n(rst_n), .f_pc(f_pc), .f_pred_npc(pred), .f_go(f_go),
      .x_valid(x_valid), .x_pc(x_pc), .x_ppc(x_ppc), .x_ok(x_ok),
      .x_kind(x_kind), .x_npc(x_npc), .x_taken(x_taken),
      .x_retire(x_retire), .x_drop(x_drop), .x_release(x_release),
      .u_valid(u_valid), .u_pc(u_pc), .u_npc(u_npc), .u_taken(u_taken),
      .u_mispred(u_mispred)
   );

   always_comb begin
      pred = f_pc + 32'd4;
      for (int k = 0; k < 2; k++)
         if (pp_en[k] && pp_from[k] == f_pc) pred = pp_to[k];
   end

   always_comb begin
      x_npc = x_pc + 32'd4;
      x_kind = 2'd0;
      for (int k = 0; k < 4; k++)
         if (pg_en[k] && pg_pc[k] == x_pc) begin
            x_npc  = pg_tgt[k];
            x_kind = pg_kind[k];
         end
      x_taken = (x_kind != 2'd0) && (x_npc != x_pc + 32'd4);
   end

   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      if (rst_n) begin
         if (x_retire) begin ret_pc[n_ret] = x_pc; ret_cyc[n_ret] = cyc; n_ret++; end
         if (x_drop) begin drop_pc[n_drop] = x_pc; n_drop++; end
         if (x_release) n_rel++;
         if (u_valid) begin
            rec_pc[n_rec] = u_pc; rec_npc[n_rec] = u_npc;
            rec_tk[n_rec] = u_taken; rec_mis[n_rec] = u_mispred; n_rec++;
         end
         if (x_valid) begin
            logic [31:0] e;
            e = x_pc + 32'd4;
            for (int k = 0; k < 2; k++)
               if (pp_en[k] && pp_from[k] == x_pc) e = pp_to[k];
            if (e != x_ppc) ppc_bad++;
         end
      end
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; f_go = 1'b0; x_ok = 1'b1;
      for (int k = 0; k < 4; k++) pg_en[k] = 1'b0;
      for (int k = 0; k < 2; k++) pp_en[k] = 1'b0;
      repeat (3) @(negedge clk);
      n_ret = 0; n_drop = 0; n_rec = 0; n_rel = 0; ppc_bad = 0;
      rst_n = 1'b1;
   endtask

   task automatic run(input int n);
      f_go = 1'b1;
      repeat (n) @(negedge clk);
      f_go = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic t_reset();
      @(negedge clk);
      rst_n = 1'b0; f_go = 1'b0;
      repeat (2) @(negedge clk);
      chk(f_pc == 32'h100, "R1 reset pc", f_pc, 32'h100);
      chk(!x_valid && !u_valid && !x_retire && !x_drop, "R1 quiet outputs",
          {x_valid, u_valid, x_retire, x_drop}, 0);
   endtask

   task automatic t_stream();
      logic [31:0] held;
      do_reset();
      run(6);
      chk(n_ret >= 5, "R3 stream retire count", n_ret, 5);
      for (int i = 0; i < 5; i++)
         chk(ret_pc[i] == 32'h100 + 32'(4 * i), "R3 sequential order", ret_pc[i],
             32'h100 + 32'(4 * i));
      chk(n_drop == 0, "R1 first instructions not dropped", n_drop, 0);
      chk(n_rec == 0, "R6 no record for plain instructions", n_rec, 0);
      chk(n_rel == n_ret, "R10 one release per retire", n_rel, n_ret);
      chk(ppc_bad == 0, "R2 predicted next carried", ppc_bad, 0);
      held = f_pc;
      repeat (3) @(negedge clk);
      chk(f_pc == held, "R3 pc holds with go low", f_pc, held);
   endtask

   task automatic t_hold();
      do_reset();
      x_ok = 1'b0; f_go = 1'b1;
      repeat (5) @(negedge clk);
      chk(f_pc == 32'h104, "R11 fetch stops when slot occupied", f_pc, 32'h104);
      chk(x_valid && x_pc == 32'h100, "R11 instruction held", x_pc, 32'h100);
      chk(n_ret == 0, "R11 no retire while not ready", n_ret, 0);
      f_go = 1'b0; x_ok = 1'b1;
      repeat (2) @(negedge clk);
      chk(n_ret == 1 && ret_pc[0] == 32'h100, "R11 retires when ready", ret_pc[0], 32'h100);
   endtask

   task automatic t_mispred();
      do_reset();
      pg_en[0] = 1'b1; pg_pc[0] = 32'h108; pg_tgt[0] = 32'h200; pg_kind[0] = 2'd3;
      pg_en[1] = 1'b1; pg_pc[1] = 32'h10C; pg_tgt[1] = 32'h400; pg_kind[1] = 2'd1;
      run(8);
      chk(ret_pc[2] == 32'h108 && ret_pc[3] == 32'h200, "R7 refetch from target",
          ret_pc[3], 32'h200);
      chk(ret_cyc[3] - ret_cyc[2] == 3, "R7 one bubble cycle", ret_cyc[3] - ret_cyc[2], 3);
      chk(n_drop == 1 && drop_pc[0] == 32'h10C, "R5 wrong path dropped", drop_pc[0], 32'h10C);
      chk(n_rec == 1, "R4 dropped jump leaves no record", n_rec, 1);
      chk(rec_pc[0] == 32'h108 && rec_npc[0] == 32'h200 && rec_tk[0] && rec_mis[0],
          "R5 mispredict record", {rec_pc[0][15:0], rec_npc[0][15:0]}, 32'h01080200);
      chk(n_rel == n_ret + n_drop, "R10 release on drop and retire", n_rel, n_ret + n_drop);
   endtask

   task automatic t_correct();
      do_reset();
      pg_en[0] = 1'b1; pg_pc[0] = 32'h108; pg_tgt[0] = 32'h200; pg_kind[0] = 2'd3;
      pp_en[0] = 1'b1; pp_from[0] = 32'h108; pp_to[0] = 32'h200;
      run(8);
      chk(n_drop == 0, "R8 nothing dropped", n_drop, 0);
      chk(n_rec == 1 && rec_pc[0] == 32'h108 && rec_tk[0] && !rec_mis[0],
          "R6 update record without mispredict", {rec_tk[0], rec_mis[0]}, 2);
      chk(ret_pc[3] == 32'h200 && ret_cyc[3] - ret_cyc[2] == 1, "R8 no bubble",
          ret_cyc[3] - ret_cyc[2], 1);
      chk(ppc_bad == 0, "R2 predicted target carried", ppc_bad, 0);
   endtask

   task automatic t_alias();
      do_reset();
      pp_en[0] = 1'b1; pp_from[0] = 32'h104; pp_to[0] = 32'h300;
      run(8);
      chk(n_rec == 1 && rec_pc[0] == 32'h104 && rec_npc[0] == 32'h108 && rec_mis[0]
          && !rec_tk[0], "R5 non-control mispredict record", rec_npc[0], 32'h108);
      chk(n_drop == 1 && drop_pc[0] == 32'h300, "R5 alias target dropped", drop_pc[0], 32'h300);
      chk(ret_pc[2] == 32'h108, "R7 resumes at correct address", ret_pc[2], 32'h108);
   endtask

   task automatic t_qfull();
      do_reset();
      pg_en[0] = 1'b1; pg_pc[0] = 32'h104; pg_tgt[0] = 32'h108; pg_kind[0] = 2'd3;
      pg_en[1] = 1'b1; pg_pc[1] = 32'h108; pg_tgt[1] = 32'h10C; pg_kind[1] = 2'd2;
      run(8);
      chk(ret_pc[1] == 32'h104 && ret_pc[2] == 32'h108, "R9 order kept", ret_pc[2], 32'h108);
      chk(ret_cyc[2] - ret_cyc[1] == 2, "R9 stall on full queue", ret_cyc[2] - ret_cyc[1], 2);
      chk(n_rec == 2 && rec_pc[1] == 32'h108 && !rec_mis[1] && !rec_tk[1],
          "R6 register jump record", rec_pc[1], 32'h108);
   endtask

   initial begin
      t_reset();
      t_stream();
      t_hold();
      t_mispred();
      t_correct();
      t_alias();
      t_qfull();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(8 * 100000);
      checks++; errors++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule